// File: doc/BRIEF.md
# Quadword Arithmetic Shifter with Overflow Detection

This unit shifts a signed 64-bit value by a signed byte count in one clock. The sign of the count picks the direction. A count from 0 to 127 shifts left. A count with its top bit set shifts right, arithmetically, by its two's-complement magnitude. A shift that needs more than 63 places saturates: a left shift gives zero, and a right shift gives a word filled with the source sign. A left shift also reports whether any significant bits were lost.

The operand arrives as two 32-bit halves, and the result leaves in the same split. A caller places the halves and the count on the inputs and raises `start` for one cycle. On the next clock edge the result and the overflow flag are registered, and `done` pulses for one cycle. Between operations the outputs keep their last value.

Top module: `qshift_unit`

## Requirements
- R1: `count` is an 8-bit two's-complement value. When bit 7 is 0, the source shifts left by `count` places. When bit 7 is 1, the source shifts right by 256 minus `count` places, which gives a magnitude of 1 to 128.
- R2: A right shift always clears `ovf`.
- R3: A right shift by 64 or more places (`count` from 0x80 to 0xC0) gives all ones for a negative source and all zeros for a non-negative source.
- R4: A right shift by 1 to 63 places is arithmetic: the vacated high bits copy source bit 63.
- R5: A left shift by 64 or more places (`count` from 0x40 to 0x7F) gives zero, and sets `ovf` exactly when the source is nonzero.
- R6: A left shift by 1 to 63 places gives the source moved left with zeros filled in. It sets `ovf` exactly when an arithmetic right shift of that result by the same count does not give back the source.
- R7: The source is {`src_hi`, `src_lo`}, with `src_lo` as bits 31:0. The result is {`res_hi`, `res_lo`} in the same arrangement.
- R8: A count of zero returns the source unchanged and clears `ovf`.
- R9: `res_hi`, `res_lo` and `ovf` update only on the rising edge at which `start` is 1, and hold otherwise. `done` is 1 for exactly the cycle after each such edge. A synchronous active-low reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Captures the operands and the count on this edge |
| src_lo | input | 32 | Bits 31:0 of the source |
| src_hi | input | 32 | Bits 63:32 of the source |
| count | input | 8 | Signed shift count |
| res_lo | output | 32 | Bits 31:0 of the result |
| res_hi | output | 32 | Bits 63:32 of the result |
| ovf | output | 1 | A left shift lost significant bits |
| done | output | 1 | One-cycle pulse: the result is valid |

## Verification
The assertions assume that `start` is a clean single-cycle strobe and that the operands and the count are stable at the edge where `start` is 1. They compare the registered outputs with the operands sampled one edge earlier. The bench drives every input at the falling edge and holds it through the capturing rising edge, so this assumption always holds. Its random counts span all 256 values, including both saturation ranges. Its random sources mix zero, small, sign-extended and full-width values, so that overflow outcomes of both kinds occur.

// File: rtl/qsh_pkg.sv
// Package: qsh_pkg
// Holds the widths shared by the shifter and its sub-blocks.
// Assumes a power-of-two data width and a count wide enough to hold DATA_W.
package qsh_pkg;
    localparam int DATA_W  = 64;
    localparam int HALF_W  = DATA_W / 2;
    localparam int CNT_W   = 8;
    localparam int AMT_W   = $clog2(DATA_W);
endpackage

// File: rtl/qsh_count_decode.sv
// Module: qsh_count_decode
// Splits a signed count into a direction, an in-range amount and a
// saturation flag. Assumes two's-complement counts; the most negative
// count has magnitude 2**(CNT_W-1).
module qsh_count_decode #(
    parameter int CNT_W  = 8,
    parameter int DATA_W = 64,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  logic [CNT_W-1:0] count,
    output logic             go_right,
    output logic             too_far,
    output logic [AMT_W-1:0] amount
);
    logic [CNT_W-1:0] mag;

    // Magnitude of the count and whether it reaches the data width.
    always_comb begin
        go_right = count[CNT_W-1];
        mag      = go_right ? (~count + 1'b1) : count;
        too_far  = (mag > CNT_W'(DATA_W - 1));
        amount   = mag[AMT_W-1:0];
    end
endmodule

// File: rtl/qsh_barrel.sv
// Module: qsh_barrel
// Logarithmic barrel shifter. In each stage the word moves by a power of
// two. Left shifts fill with zero; right shifts fill with fill_bit.
// Assumes that amount is below DATA_W.
module qsh_barrel #(
    parameter int DATA_W = 64,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [AMT_W-1:0]  amount,
    input  logic              to_left,
    input  logic              fill_bit,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] stage [AMT_W+1];

    assign stage[0] = din;

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        localparam int STEP = 1 << s;
        // One stage: shift by STEP when this bit of the amount is set.
        always_comb begin
            if (!amount[s])
                stage[s+1] = stage[s];
            else if (to_left)
                stage[s+1] = {stage[s][DATA_W-STEP-1:0], {STEP{1'b0}}};
            else
                stage[s+1] = {{STEP{fill_bit}}, stage[s][DATA_W-1:STEP]};
        end
    end

    assign dout = stage[AMT_W];
endmodule

// File: rtl/qsh_core.sv
// Module: qsh_core
// Combinational shift with overflow detection. For an in-range left shift it
// shifts the result back right, arithmetically, and compares it with the
// source. Out-of-range counts saturate.
// Assumes the decoded count comes from qsh_count_decode.
module qsh_core #(
    parameter int DATA_W = 64,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] src,
    input  logic              go_right,
    input  logic              too_far,
    input  logic [AMT_W-1:0]  amount,
    output logic [DATA_W-1:0] result,
    output logic              lost_bits
);
    logic [DATA_W-1:0] moved;
    logic [DATA_W-1:0] undone;

    qsh_barrel #(.DATA_W(DATA_W)) u_fwd (
        .din(src), .amount(amount), .to_left(!go_right),
        .fill_bit(src[DATA_W-1]), .dout(moved)
    );

    qsh_barrel #(.DATA_W(DATA_W)) u_back (
        .din(moved), .amount(amount), .to_left(1'b0),
        .fill_bit(moved[DATA_W-1]), .dout(undone)
    );

    // Pick the saturated or the shifted word, and the overflow outcome.
    always_comb begin
        if (too_far)
            result = go_right ? {DATA_W{src[DATA_W-1]}} : '0;
        else
            result = moved;
        if (go_right)
            lost_bits = 1'b0;
        else if (too_far)
            lost_bits = (src != '0);
        else
            lost_bits = (undone != src);
    end
endmodule

// File: rtl/qshift_unit.sv
// Module: qshift_unit
// Top level. Registers the result, the overflow flag and a done pulse on the
// edge where start is high. Assumes the inputs are stable at that edge.
// Synchronous active-low reset.
module qshift_unit
    import qsh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [HALF_W-1:0] src_lo,
    input  logic [HALF_W-1:0] src_hi,
    input  logic [CNT_W-1:0]  count,
    output logic [HALF_W-1:0] res_lo,
    output logic [HALF_W-1:0] res_hi,
    output logic              ovf,
    output logic              done
);
    logic              go_right;
    logic              too_far;
    logic [AMT_W-1:0]  amount;
    logic [DATA_W-1:0] result;
    logic              lost_bits;

    qsh_count_decode #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_dec (
        .count(count), .go_right(go_right), .too_far(too_far), .amount(amount)
    );

    qsh_core #(.DATA_W(DATA_W)) u_core (
        .src({src_hi, src_lo}), .go_right(go_right), .too_far(too_far),
        .amount(amount), .result(result), .lost_bits(lost_bits)
    );

    // Output registers: capture on start, done follows start by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_lo <= '0;
            res_hi <= '0;
            ovf    <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                res_lo <= result[HALF_W-1:0];
                res_hi <= result[DATA_W-1:HALF_W];
                ovf    <= lost_bits;
            end
        end
    end
endmodule

// File: rtl/qshift_unit_chk.sv
// Module: qshift_unit_chk
// Property checker for qshift_unit, attached with bind. Assumes start is
// sampled at the same edge as the operands.
module qshift_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [31:0] src_lo,
    input logic [31:0] src_hi,
    input logic [7:0]  count,
    input logic [31:0] res_lo,
    input logic [31:0] res_hi,
    input logic        ovf,
    input logic        done
);
    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) start |=> done); // R9
    AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !start |=> !done); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !start |=> ($stable(res_lo) && $stable(res_hi) && $stable(ovf))); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (start && count[7]) |=> !ovf); // R2
    AST_RIGHT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n) (start && count[7] && count < 8'hC1) |=> ({res_hi, res_lo} == {64{$past(src_hi[31])}})); // R3
    AST_LEFT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n) (start && !count[7] && count > 8'd63) |=> ({res_hi, res_lo} == 64'd0 && ovf == ($past({src_hi, src_lo}) != 64'd0))); // R5
    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (start && count == 8'd0) |=> ({res_hi, res_lo} == $past({src_hi, src_lo}) && !ovf)); // R8
endmodule

bind qshift_unit qshift_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .src_lo(src_lo), .src_hi(src_hi),
    .count(count), .res_lo(res_lo), .res_hi(res_hi), .ovf(ovf), .done(done)
);

// File: tb/tb_qshift_unit.sv
module tb_qshift_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] src_lo = '0;
    logic [31:0] src_hi = '0;
    logic [7:0]  count = '0;
    logic [31:0] res_lo;
    logic [31:0] res_hi;
    logic        ovf;
    logic        done;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    qshift_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .src_lo(src_lo), .src_hi(src_hi),
        .count(count), .res_lo(res_lo), .res_hi(res_hi), .ovf(ovf), .done(done)
    );

    // Expected {ovf, result} from the requirements.
    function automatic logic [64:0] model(input logic [63:0] src, input logic [7:0] c);
        logic signed [63:0] s;
        logic signed [63:0] r;
        int m;
        s = src;
        if (c[7]) begin
            m = 256 - int'(c);
            if (m > 63) r = src[63] ? -64'sd1 : 64'sd0;   // R3
            else r = s >>> m;                             // R4
            return {1'b0, r};                             // R2
        end
        m = int'(c);
        if (m > 63) return {(src != 64'd0), 64'd0};       // R5
        r = s <<< m;                                      // R6
        return {((r >>> m) != s), r};
    endfunction

    function automatic string tag(input logic [7:0] c);
        if (c == 8'd0) return "R8";
        if (c[7]) return (c < 8'hC1) ? "R3" : "R4";
        return (c > 8'd63) ? "R5" : "R6";
    endfunction

    task automatic check(input string req, input logic [64:0] act, input logic [64:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [63:0] src, input logic [7:0] c);
        logic [64:0] e;
        @(negedge clk);
        src_hi = src[63:32]; src_lo = src[31:0]; count = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        e = model(src, c);
        check(tag(c), {ovf, res_hi, res_lo}, e);
        check("R9 done", {64'd0, done}, 65'd1);
    endtask

    initial begin
        repeat (1000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] rs;
        logic [7:0]  rc;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R9 reset", {ovf, res_hi, res_lo}, 65'd0);
        check("R9 reset done", {64'd0, done}, 65'd0);
        rst_n = 1'b1;
        run_op(64'hDEAD_BEEF_0123_4567, 8'd0);          // R8
        run_op(64'h8000_0000_0000_0001, 8'h80);         // R3 negative, 128
        run_op(64'h7FFF_FFFF_FFFF_FFFF, 8'h80);         // R3 positive
        run_op(64'h8123_4567_89AB_CDEF, 8'hC0);         // R3 right 64
        run_op(64'h8123_4567_89AB_CDEF, 8'hC1);         // R4 right 63
        run_op(64'hF000_0000_0000_0000, 8'hFF);         // R4 R1 right 1
        run_op(64'h0000_0000_0000_0001, 8'h7F);         // R5 nonzero
        run_op(64'h0, 8'd100);                          // R5 zero source
        run_op(64'h0000_0000_0000_0001, 8'd62);         // R6 no ovf
        run_op(64'h0000_0000_0000_0001, 8'd63);         // R6 sign change
        run_op(64'h4000_0000_0000_0000, 8'd1);          // R6 ovf
        run_op(64'hFFFF_FFFF_FFFF_FFF0, 8'd4);          // R6 negative, no ovf
        run_op(64'h0000_0000_1234_5678, 8'd32);         // R7 halves move
        @(negedge clk);
        check("R9 idle done", {64'd0, done}, 65'd0);
        src_lo = 32'hFFFF_FFFF; src_hi = 32'h1; count = 8'd3;
        @(negedge clk);
        check("R9 hold", {ovf, res_hi, res_lo}, model(64'h0000_0000_1234_5678, 8'd32));
        for (int i = 0; i < 400; i++) begin
            rc = 8'($urandom);
            case ($urandom % 4)
                0: rs = {32'd0, 32'($urandom) >> ($urandom % 32)};
                1: rs = {64{1'b1}} << ($urandom % 64);
                2: rs = 64'($signed(32'($urandom)));
                default: rs = {32'($urandom), 32'($urandom)};
            endcase
            run_op(rs, rc);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule